// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node directory for one slice of memory in a directory-based cache-coherence system. It keeps one entry for each line slot: an address tag, a three-valued line state (invalid, shared, modified) and the ID of the owning core. Cores send load or store requests. The controller looks up the line and works out which probe, if any, the current state calls for. It sends that probe and waits for the acknowledgements. It then writes the new state and owner back and signals completion to the requester.

The controller handles one request at a time, in the order the requests arrive. While a request is in flight, the controller holds off new requests. The table is direct-mapped: the low address bits select a slot and the remaining bits form the tag. A request whose tag does not match the stored tag replaces the slot, and the line is treated as uncached. A store sets the owner to the requesting core. A load keeps the stored owner.

Top module: `dir_home_ctrl`

## Requirements
- R1: While and after reset, `req_ready_o` is 1 and `probe_valid_o` and `resp_valid_o` are 0. Every slot holds tag 0, owner 0 and state invalid (code 0).
- R2: A load to a line in invalid or shared state sends no probe. `resp_valid_o` pulses in the cycle after acceptance, with `resp_state_o` = shared (code 1).
- R3: A load to a line in modified state (code 2) sends a direct forward probe (`probe_kind_o` = 2) to the stored owner. The line then becomes shared and keeps the same owner.
- R4: A store to a line in invalid state sends no probe. The line becomes modified, with the owner set to the requester.
- R5: A store to a shared line sends a broadcast invalidate (`probe_kind_o` = 1) with `probe_core_o` = the requester. It needs NUM_CORES-1 acknowledgements. The line becomes modified and owned by the requester.
- R6: A store to a modified line sends a direct invalidate (`probe_kind_o` = 3) to the old owner and needs one acknowledgement. The line becomes modified and owned by the requester.
- R7: A request whose tag differs from the stored tag of its slot is handled as a hit on an invalid line with owner 0. The new tag is then stored.
- R8: `resp_valid_o` rises only in the cycle after the last required acknowledgement. Pulses on `ack_i` while no request waits for acknowledgements are ignored.
- R9: Requests are accepted one at a time. `req_ready_o` is 0 from the cycle after acceptance until the cycle after the completion pulse. Each request produces at most one single-cycle probe and exactly one single-cycle `resp_valid_o`.
- R10: `probe_addr_o` carries the address of the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Line address |
| req_core_i | input | CORE_W | Requesting core |
| probe_valid_o | output | 1 | Probe issued this cycle |
| probe_kind_o | output | 2 | 1 broadcast invalidate, 2 forward, 3 direct invalidate |
| probe_core_o | output | CORE_W | Target owner, or the excluded requester for a broadcast |
| probe_addr_o | output | ADDR_W | Address of the request in flight |
| ack_i | input | 1 | One probe acknowledgement |
| resp_valid_o | output | 1 | Request complete |
| resp_state_o | output | 2 | New line state (0 I, 1 S, 2 M) |
| resp_owner_o | output | CORE_W | Owner recorded for the line |

## Verification
Assertions check the following on every cycle:
- probes last one cycle;
- no completion coincides with a probe;
- acceptance drops the ready signal;
- a load that hits a modified line is followed by a forward probe to the recorded owner;
- a tag miss never produces a probe.

The bench scenarios cover what depends on history:
- the full state and owner sequence across many requests;
- aliasing addresses that evict a slot;
- exact acknowledgement counting with idle gaps;
- stray acknowledgements while idle.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    PRB_NONE      = 2'd0,
    PRB_BCAST_INV = 2'd1,
    PRB_FWD       = 2'd2,
    PRB_OWN_INV   = 2'd3
  } probe_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_DONE
  } seq_e;
endpackage

// File: rtl/dir_table.sv
module dir_table #(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3,
  parameter int TAG_W       = 5,
  parameter int CORE_W      = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [TAG_W-1:0]      rd_tag_o,
  output dirc_pkg::line_st_e    rd_state_o,
  output logic [CORE_W-1:0]     rd_owner_o,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [TAG_W-1:0]      wr_tag_i,
  input  dirc_pkg::line_st_e    wr_state_i,
  input  logic [CORE_W-1:0]     wr_owner_i
);
  import dirc_pkg::*;

  logic [TAG_W-1:0]  tag_q   [NUM_ENTRIES];
  line_st_e          state_q [NUM_ENTRIES];
  logic [CORE_W-1:0] owner_q [NUM_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        tag_q[e]   <= '0;
        state_q[e] <= LINE_I;
        owner_q[e] <= '0;
      end
    end else if (wr_en_i) begin
      tag_q[wr_idx_i]   <= wr_tag_i;
      state_q[wr_idx_i] <= wr_state_i;
      owner_q[wr_idx_i] <= wr_owner_i;
    end
  end

  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_state_o = state_q[rd_idx_i];
  assign rd_owner_o = owner_q[rd_idx_i];
endmodule

// File: rtl/dir_policy.sv
module dir_policy #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int ACK_W     = 3
) (
  input  logic               is_store_i,
  input  logic               hit_i,
  input  dirc_pkg::line_st_e st_i,
  input  logic [CORE_W-1:0]  owner_i,
  input  logic [CORE_W-1:0]  core_i,
  output dirc_pkg::probe_e   kind_o,
  output logic [CORE_W-1:0]  target_o,
  output logic [ACK_W-1:0]   acks_o,
  output dirc_pkg::line_st_e next_st_o,
  output logic [CORE_W-1:0]  next_owner_o
);
  import dirc_pkg::*;

  localparam logic [ACK_W-1:0] BCAST_ACKS = ACK_W'(NUM_CORES - 1);

  line_st_e          eff_st;
  logic [CORE_W-1:0] eff_owner;

  // a tag miss behaves as a freshly allocated invalid slot
  assign eff_st    = hit_i ? st_i : LINE_I;
  assign eff_owner = hit_i ? owner_i : '0;

  always_comb begin
    kind_o   = PRB_NONE;
    target_o = eff_owner;
    acks_o   = ACK_W'(1);
    if (is_store_i) begin
      unique case (eff_st)
        LINE_S: begin
          kind_o   = PRB_BCAST_INV;
          target_o = core_i;
          acks_o   = BCAST_ACKS;
        end
        LINE_M:  kind_o = PRB_OWN_INV;
        default: kind_o = PRB_NONE;
      endcase
    end else if (eff_st == LINE_M) begin
      kind_o = PRB_FWD;
    end
  end

  assign next_st_o    = is_store_i ? LINE_M : LINE_S;
  assign next_owner_o = is_store_i ? core_i : eff_owner;
endmodule

// File: rtl/dir_seq.sv
module dir_seq #(
  parameter int ADDR_W = 8,
  parameter int CORE_W = 2,
  parameter int ACK_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               req_ready_o,
  output logic               accept_o,
  input  dirc_pkg::probe_e   kind_i,
  input  logic [CORE_W-1:0]  target_i,
  input  logic [ACK_W-1:0]   acks_i,
  input  dirc_pkg::line_st_e next_st_i,
  input  logic [CORE_W-1:0]  next_owner_i,
  input  logic               ack_i,
  output logic               probe_valid_o,
  output dirc_pkg::probe_e   probe_kind_o,
  output logic [CORE_W-1:0]  probe_core_o,
  output logic [ADDR_W-1:0]  probe_addr_o,
  output logic               resp_valid_o,
  output dirc_pkg::line_st_e resp_state_o,
  output logic [CORE_W-1:0]  resp_owner_o,
  output logic               wr_en_o
);
  import dirc_pkg::*;

  seq_e              state_q;
  probe_e            kind_q;
  logic [CORE_W-1:0] target_q, owner_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ACK_W-1:0]  rem_q;
  line_st_e          nst_q;

  assign req_ready_o = (state_q == SQ_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SQ_IDLE;
      kind_q   <= PRB_NONE;
      target_q <= '0;
      owner_q  <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
      nst_q    <= LINE_I;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (accept_o) begin
          kind_q   <= kind_i;
          target_q <= target_i;
          owner_q  <= next_owner_i;
          addr_q   <= req_addr_i;
          rem_q    <= acks_i;
          nst_q    <= next_st_i;
          state_q  <= (kind_i == PRB_NONE) ? SQ_DONE : SQ_ISSUE;
        end
        SQ_ISSUE, SQ_WAIT: begin
          if (ack_i) begin
            if (rem_q == ACK_W'(1)) state_q <= SQ_DONE;
            else begin
              rem_q   <= rem_q - ACK_W'(1);
              state_q <= SQ_WAIT;
            end
          end else begin
            state_q <= SQ_WAIT;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign probe_valid_o = (state_q == SQ_ISSUE);
  assign probe_kind_o  = kind_q;
  assign probe_core_o  = target_q;
  assign probe_addr_o  = addr_q;
  assign resp_valid_o  = (state_q == SQ_DONE);
  assign resp_state_o  = nst_q;
  assign resp_owner_o  = owner_q;
  assign wr_en_o       = resp_valid_o;

  AST_PROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_o |=> !probe_valid_o); // R9
  AST_PROBE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_o |-> probe_kind_o != PRB_NONE); // R3
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !req_ready_o); // R9
  AST_NO_EARLY_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_o |-> !resp_valid_o); // R8
  AST_RESP_THEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> req_ready_o); // R9
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NUM_CORES   = 4,
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 8,
  parameter int CORE_W      = $clog2(NUM_CORES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CORE_W-1:0] req_core_i,
  output logic              probe_valid_o,
  output logic [1:0]        probe_kind_o,
  output logic [CORE_W-1:0] probe_core_o,
  output logic [ADDR_W-1:0] probe_addr_o,
  input  logic              ack_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_state_o,
  output logic [CORE_W-1:0] resp_owner_o
);
  import dirc_pkg::*;

  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int ACK_W = $clog2(NUM_CORES) + 1;

  logic [TAG_W-1:0]  rd_tag;
  line_st_e          rd_state;
  logic [CORE_W-1:0] rd_owner;
  logic              hit, accept, wr_en;
  probe_e            kind, p_kind;
  logic [CORE_W-1:0] target, next_owner;
  logic [ACK_W-1:0]  acks;
  line_st_e          next_st, r_state;

  dir_table #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .CORE_W(CORE_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (req_addr_i[IDX_W-1:0]),
    .rd_tag_o   (rd_tag),
    .rd_state_o (rd_state),
    .rd_owner_o (rd_owner),
    .wr_en_i    (wr_en),
    .wr_idx_i   (probe_addr_o[IDX_W-1:0]),
    .wr_tag_i   (probe_addr_o[ADDR_W-1:IDX_W]),
    .wr_state_i (r_state),
    .wr_owner_i (resp_owner_o)
  );

  assign hit = (rd_tag == req_addr_i[ADDR_W-1:IDX_W]);

  dir_policy #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .ACK_W(ACK_W)
  ) u_policy (
    .is_store_i   (req_store_i),
    .hit_i        (hit),
    .st_i         (rd_state),
    .owner_i      (rd_owner),
    .core_i       (req_core_i),
    .kind_o       (kind),
    .target_o     (target),
    .acks_o       (acks),
    .next_st_o    (next_st),
    .next_owner_o (next_owner)
  );

  dir_seq #(
    .ADDR_W(ADDR_W), .CORE_W(CORE_W), .ACK_W(ACK_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_addr_i    (req_addr_i),
    .req_ready_o   (req_ready_o),
    .accept_o      (accept),
    .kind_i        (kind),
    .target_i      (target),
    .acks_i        (acks),
    .next_st_i     (next_st),
    .next_owner_i  (next_owner),
    .ack_i         (ack_i),
    .probe_valid_o (probe_valid_o),
    .probe_kind_o  (p_kind),
    .probe_core_o  (probe_core_o),
    .probe_addr_o  (probe_addr_o),
    .resp_valid_o  (resp_valid_o),
    .resp_state_o  (r_state),
    .resp_owner_o  (resp_owner_o),
    .wr_en_o       (wr_en)
  );

  assign probe_kind_o = p_kind;
  assign resp_state_o = r_state;

  AST_FWD_TO_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit && rd_state == LINE_M && !req_store_i)
      |=> (probe_valid_o && p_kind == PRB_FWD && probe_core_o == $past(rd_owner))); // R3
  AST_MISS_NO_PROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !hit) |=> !probe_valid_o); // R7
endmodule

// File: tb/dir_home_ctrl_tb_top.sv
module dir_home_ctrl_tb_top;
  localparam int NC     = 4;
  localparam int NE     = 8;
  localparam int ADDR_W = 8;
  localparam int CORE_W = 2;
  localparam int IDX_W  = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o, req_store_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [CORE_W-1:0] req_core_i = '0;
  logic probe_valid_o;
  logic [1:0] probe_kind_o;
  logic [CORE_W-1:0] probe_core_o;
  logic [ADDR_W-1:0] probe_addr_o;
  logic ack_i = 1'b0;
  logic resp_valid_o;
  logic [1:0] resp_state_o;
  logic [CORE_W-1:0] resp_owner_o;

  always #10 clk_i = ~clk_i;

  dir_home_ctrl #(.NUM_CORES(NC), .NUM_ENTRIES(NE), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_store_i(req_store_i),
    .req_addr_i(req_addr_i), .req_core_i(req_core_i),
    .probe_valid_o(probe_valid_o), .probe_kind_o(probe_kind_o),
    .probe_core_o(probe_core_o), .probe_addr_o(probe_addr_o),
    .ack_i(ack_i), .resp_valid_o(resp_valid_o),
    .resp_state_o(resp_state_o), .resp_owner_o(resp_owner_o)
  );

  int n_checks = 0, n_errs = 0;
  bit done = 1'b0;
  int m_st [NE];
  int m_tag [NE];
  int m_own [NE];

  task automatic chk(input string rq, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // 0 none, 1 bcast inv, 2 forward, 3 direct inv
  function automatic int exp_kind(input bit st, input int ls);
    if (!st) return (ls == 2) ? 2 : 0;
    if (ls == 1) return 1;
    if (ls == 2) return 3;
    return 0;
  endfunction

  function automatic string kind_req(input bit st, input int k);
    if (k == 1) return "R5";
    if (k == 3) return "R6";
    if (k == 2) return "R3";
    return st ? "R4" : "R2";
  endfunction

  task automatic do_req(input bit st, input int a, input int c, input bit gaps);
    int idx, tg, ls, lo, k, tgt, na, ns, no;
    string rq;
    idx = a % NE;
    tg  = a / NE;
    ls  = (m_tag[idx] == tg) ? m_st[idx] : 0;
    lo  = (m_tag[idx] == tg) ? m_own[idx] : 0;
    k   = exp_kind(st, ls);
    tgt = (k == 1) ? c : lo;
    na  = (k == 1) ? NC - 1 : 1;
    ns  = st ? 2 : 1;
    no  = st ? c : lo;
    rq  = (m_tag[idx] != tg) ? "R7" : kind_req(st, k);
    @(negedge clk_i);
    chk("R9 ready before request", int'(req_ready_o), 1);
    req_valid_i = 1'b1; req_store_i = st;
    req_addr_i = ADDR_W'(a); req_core_i = CORE_W'(c);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R9 ready low in flight", int'(req_ready_o), 0);
    chk("R10 probe address", int'(probe_addr_o), a);
    if (k == 0) begin
      chk({rq, " no probe"}, int'(probe_valid_o), 0);
      chk({rq, " immediate completion"}, int'(resp_valid_o), 1);
    end else begin
      chk({rq, " probe valid"}, int'(probe_valid_o), 1);
      chk({rq, " probe kind"}, int'(probe_kind_o), k);
      chk({rq, " probe target"}, int'(probe_core_o), tgt);
      chk("R8 no completion with probe", int'(resp_valid_o), 0);
      for (int i = 0; i < na; i++) begin
        if (gaps && ($urandom % 2 == 0)) begin
          @(negedge clk_i);
          chk("R8 wait without ack", int'(resp_valid_o), 0);
          chk("R9 single probe", int'(probe_valid_o), 0);
        end
        ack_i = 1'b1;
        @(negedge clk_i);
        ack_i = 1'b0;
        if (i < na - 1) chk("R8 early completion", int'(resp_valid_o), 0);
      end
      chk("R8 completion after last ack", int'(resp_valid_o), 1);
    end
    chk({rq, " new state"}, int'(resp_state_o), ns);
    chk({rq, " new owner"}, int'(resp_owner_o), no);
    m_tag[idx] = tg; m_st[idx] = ns; m_own[idx] = no;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    for (int e = 0; e < NE; e++) begin m_st[e] = 0; m_tag[e] = 0; m_own[e] = 0; end
    repeat (2) @(negedge clk_i);
    chk("R1 ready in reset", int'(req_ready_o), 1);
    chk("R1 probe idle in reset", int'(probe_valid_o), 0);
    chk("R1 resp idle in reset", int'(resp_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready after reset", int'(req_ready_o), 1);
    // directed sequence on line 5
    do_req(1'b0, 5, 1, 1'b0);   // I load
    do_req(1'b0, 5, 2, 1'b0);   // S load
    do_req(1'b1, 5, 3, 1'b0);   // S store: broadcast
    do_req(1'b0, 5, 0, 1'b0);   // M load: forward to 3
    do_req(1'b1, 5, 1, 1'b1);   // S store
    do_req(1'b1, 5, 2, 1'b0);   // M store: direct inv to 1
    do_req(1'b1, 5 + NE, 0, 1'b0); // alias: miss
    do_req(1'b1, 5, 3, 1'b0);   // miss again, owner 0 in model
    // stray acks while idle
    @(negedge clk_i);
    ack_i = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      chk("R8 stray ack no response", int'(resp_valid_o), 0);
      chk("R8 stray ack no probe", int'(probe_valid_o), 0);
    end
    ack_i = 1'b0;
    do_req(1'b0, 5, 1, 1'b1);   // M load still needs its own ack
    for (int n = 0; n < 300; n++)
      do_req(1'($urandom % 2), int'($urandom % 32), int'($urandom % NC), 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end
endmodule